// File: doc/BRIEF.md
# Approximation-Aware Voltage Step Controller

This block sits beside one processor core and decides, transaction by transaction, whether a timing violation must be repaired by rollback or can be tolerated, and which supply-voltage step the core should run at. Software opens a transaction and, in the same cycle, hands the block an error budget. Timing violations are reported together with a flag. The flag says whether the failing operation could tolerate approximation (floating-point add, multiply, copy or negate) or could not (loads, stores, moves between integer and floating-point registers). The checkpoint and rollback machinery and the regulator are outside the block. It only requests aborts and publishes a step index.

Voltage is managed from commit history alone. A long run of clean commits shows that the core has margin, so the voltage is lowered one step. An abort that comes soon after the previous one shows that the voltage is too low, so it is raised one step. Both thresholds can be reprogrammed, and they do not depend on how long a transaction is. The step index covers supply levels from nominal down to 0.7 of nominal, in steps of 0.05.

Top module: `avs_ctrl`

## Requirements
- R1: After reset the step index is 0 (nominal supply), abort_req is 0, ign_cnt and commit_cnt are 0, the lowering threshold is 100 and the raising threshold is 10.
- R2: A violation with viol_approx=0 inside an open transaction raises abort_req for exactly one cycle, in the cycle after the event, and closes the transaction.
- R3: Each violation with viol_approx=1 inside an open transaction increments ign_cnt, as long as the new count does not exceed the budget. The violation that would take the count above the budget causes an abort instead (R2 timing). A budget of 0 therefore aborts on the first such violation.
- R4: txn_start opens a transaction, loads txn_budget and clears ign_cnt. Other events in that cycle are ignored. An abort also clears ign_cnt.
- R5: Violations and commits while no transaction is open have no effect on any output.
- R6: A commit closes the transaction and increments commit_cnt. When the incremented count would exceed the lowering threshold, the step index rises by 1 (lower supply) and commit_cnt becomes 0.
- R7: On an abort, if commit_cnt is below the raising threshold, the step index falls by 1 (higher supply). commit_cnt becomes 0 on every abort.
- R8: The step index saturates at 0 and at 6 (index s means a supply of 1.0 - 0.05*s of nominal).
- R9: A configuration write with cfg_sel=0 sets the lowering threshold and one with cfg_sel=1 sets the raising threshold. Each takes effect for events in the following cycles.
- R10: When a violation that aborts and a commit arrive in the same cycle, the abort wins and the commit is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Threshold write strobe |
| cfg_sel | input | 1 | 0 = lowering threshold, 1 = raising threshold |
| cfg_wdata | input | 8 | Threshold value |
| txn_start | input | 1 | Transaction open (or retry) |
| txn_budget | input | 4 | Tolerated approximatable errors for this transaction |
| txn_commit | input | 1 | Transaction commit |
| viol_valid | input | 1 | Timing violation event |
| viol_approx | input | 1 | 1 = violation on an approximatable operation |
| abort_req | output | 1 | One-cycle abort request |
| vstep | output | 3 | Voltage step index, 0 = nominal |
| ign_cnt | output | 4 | Errors ignored in the current transaction |
| commit_cnt | output | 8 | Consecutive commits since the last abort or lowering |

## Verification
The bench sweeps budgets 0 to 3 against 0 to 5 approximatable violations per transaction, so the abort falls exactly on the violation that exceeds the budget. A comparison that is off by one would either abort early or let one extra error through. Thresholds of 100/10 after reset and small programmed ones are both run to their edges. A wrong comparison would move the step one commit too early or too late, or raise the voltage on an abort that came after enough commits. The step is driven into both ends of its range, where a missing saturation would wrap around. Idle-time events and a commit in the same cycle as an aborting violation are also covered, where a faulty design would count the commit or abort with no transaction open.

// File: rtl/avs_pkg.sv
// Shared types for the approximation-aware voltage step controller.
// Assumes: one controller per core, all logic in one clock domain.
package avs_pkg;

    // Selects which commit threshold a configuration write targets.
    typedef enum logic {
        THR_LOWER = 1'b0,   // commits needed before the supply is lowered
        THR_RAISE = 1'b1    // commits below which an abort raises the supply
    } thr_sel_e;

    // Single-cycle request from the commit tracker to the step register.
    typedef struct packed {
        logic lower;    // move one step toward lower supply
        logic raise;    // move one step toward nominal supply
    } step_req_t;

endpackage

// File: rtl/avs_txn_monitor.sv
// Transaction monitor: tracks whether a transaction is open, holds its
// error budget and the count of tolerated violations, and decides when
// a violation forces an abort. txn_start has priority over all events.
// Assumes: events outside an open transaction are meaningless and dropped.
module avs_txn_monitor #(
    parameter int BUD_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             txn_start,
    input  logic [BUD_W-1:0] txn_budget,
    input  logic             txn_commit,
    input  logic             viol_valid,
    input  logic             viol_approx,
    output logic             abort_o,
    output logic             commit_o,
    output logic             open_o,
    output logic [BUD_W-1:0] ign_o
);
    localparam int EXT_W = BUD_W + 1;

    logic             open_q;
    logic [BUD_W-1:0] bud_q;
    logic [BUD_W-1:0] ign_q;
    logic             over_budget;
    logic             live;

    // Decide abort and commit for the current cycle.
    always_comb begin
        live        = open_q && !txn_start;
        over_budget = (EXT_W'(ign_q) + EXT_W'(1)) > EXT_W'(bud_q);
        abort_o     = live && viol_valid && (!viol_approx || over_budget);
        commit_o    = live && txn_commit && !abort_o;
    end

    // Update transaction state, budget and tolerated-error count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            bud_q  <= '0;
            ign_q  <= '0;
        end else if (txn_start) begin
            open_q <= 1'b1;
            bud_q  <= txn_budget;
            ign_q  <= '0;
        end else if (abort_o) begin
            open_q <= 1'b0;
            ign_q  <= '0;
        end else begin
            if (live && viol_valid) begin
                ign_q <= ign_q + BUD_W'(1);
            end
            if (commit_o) begin
                open_q <= 1'b0;
            end
        end
    end

    assign open_o = open_q;
    assign ign_o  = ign_q;

    AST_IGN_WITHIN_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
        open_q |-> (ign_q <= bud_q)); // R3
    AST_START_CLEARS_IGN: assert property (@(posedge clk) disable iff (!rst_n)
        txn_start |=> (open_q && ign_q == '0)); // R4

endmodule

// File: rtl/avs_commit_tracker.sv
// Commit tracker: holds the two programmable thresholds and the count of
// consecutive commits, and issues lower/raise step requests.
// Assumes: abort_i and commit_i are never both high (monitor guarantees).
module avs_commit_tracker
    import avs_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int DEF_HIGH = 100,
    parameter int DEF_LOW  = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_en,
    input  logic             cfg_sel,
    input  logic [CNT_W-1:0] cfg_wdata,
    input  logic             abort_i,
    input  logic             commit_i,
    output step_req_t        req_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam int EXT_W = CNT_W + 1;

    logic [CNT_W-1:0] high_q;
    logic [CNT_W-1:0] low_q;
    logic [CNT_W-1:0] cnt_q;
    logic [EXT_W-1:0] cnt_inc;
    logic             past_high;

    // Work out the next count and whether a step request is due.
    always_comb begin
        cnt_inc     = EXT_W'(cnt_q) + EXT_W'(1);
        past_high   = cnt_inc > EXT_W'(high_q);
        req_o.lower = commit_i && past_high;
        req_o.raise = abort_i && (cnt_q < low_q);
    end

    // Hold the thresholds written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            high_q <= CNT_W'(DEF_HIGH);
            low_q  <= CNT_W'(DEF_LOW);
        end else if (cfg_wr_en) begin
            if (thr_sel_e'(cfg_sel) == THR_LOWER) begin
                high_q <= cfg_wdata;
            end else begin
                low_q <= cfg_wdata;
            end
        end
    end

    // Count consecutive commits; clear on abort and on lowering.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (abort_i) begin
            cnt_q <= '0;
        end else if (commit_i) begin
            cnt_q <= past_high ? '0 : cnt_inc[CNT_W-1:0];
        end
    end

    assign cnt_o = cnt_q;

    AST_ABORT_CLEARS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> (cnt_q == '0)); // R7
    AST_NO_DOUBLE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !(abort_i && commit_i)); // R10

endmodule

// File: rtl/avs_step_reg.sv
// Step register: saturating voltage step index, 0 = nominal supply,
// MAX_STEP = lowest permitted supply.
// Assumes: lower and raise requests are mutually exclusive.
module avs_step_reg
    import avs_pkg::*;
#(
    parameter int MAX_STEP = 6,
    parameter int STEP_W   = $clog2(MAX_STEP + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  step_req_t         req_i,
    output logic [STEP_W-1:0] step_o
);
    localparam logic [STEP_W-1:0] TOP = STEP_W'(MAX_STEP);

    logic [STEP_W-1:0] step_q;

    // Apply one step request, holding at either end of the range.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= '0;
        end else if (req_i.lower && step_q != TOP) begin
            step_q <= step_q + STEP_W'(1);
        end else if (req_i.raise && step_q != '0) begin
            step_q <= step_q - STEP_W'(1);
        end
    end

    assign step_o = step_q;

    AST_STEP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        step_q <= TOP); // R8
    AST_STEP_ONE_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q != $past(step_q)) |->
        ((step_q == $past(step_q) + STEP_W'(1)) || (step_q + STEP_W'(1) == $past(step_q)))); // R6

endmodule

// File: rtl/avs_ctrl.sv
// Top of the approximation-aware voltage step controller. Connects the
// transaction monitor, commit tracker and step register, and registers
// the abort request so it is a clean one-cycle pulse.
// Assumes: the rollback engine reacts to abort_req and software issues
// txn_start again for the retry.
module avs_ctrl
    import avs_pkg::*;
#(
    parameter int BUD_W    = 4,
    parameter int CNT_W    = 8,
    parameter int MAX_STEP = 6,
    parameter int DEF_HIGH = 100,
    parameter int DEF_LOW  = 10,
    parameter int STEP_W   = $clog2(MAX_STEP + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic              cfg_sel,
    input  logic [CNT_W-1:0]  cfg_wdata,
    input  logic              txn_start,
    input  logic [BUD_W-1:0]  txn_budget,
    input  logic              txn_commit,
    input  logic              viol_valid,
    input  logic              viol_approx,
    output logic              abort_req,
    output logic [STEP_W-1:0] vstep,
    output logic [BUD_W-1:0]  ign_cnt,
    output logic [CNT_W-1:0]  commit_cnt
);
    logic      abort_now;
    logic      commit_now;
    logic      txn_open;
    step_req_t step_req;
    logic      abort_q;

    avs_txn_monitor #(.BUD_W(BUD_W)) u_mon (
        .clk         (clk),
        .rst_n       (rst_n),
        .txn_start   (txn_start),
        .txn_budget  (txn_budget),
        .txn_commit  (txn_commit),
        .viol_valid  (viol_valid),
        .viol_approx (viol_approx),
        .abort_o     (abort_now),
        .commit_o    (commit_now),
        .open_o      (txn_open),
        .ign_o       (ign_cnt)
    );

    avs_commit_tracker #(
        .CNT_W    (CNT_W),
        .DEF_HIGH (DEF_HIGH),
        .DEF_LOW  (DEF_LOW)
    ) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr_en (cfg_wr_en),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .abort_i   (abort_now),
        .commit_i  (commit_now),
        .req_o     (step_req),
        .cnt_o     (commit_cnt)
    );

    avs_step_reg #(
        .MAX_STEP (MAX_STEP),
        .STEP_W   (STEP_W)
    ) u_step (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (step_req),
        .step_o (vstep)
    );

    // Register the abort decision into a one-cycle request pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abort_q <= 1'b0;
        end else begin
            abort_q <= abort_now;
        end
    end

    assign abort_req = abort_q;

    AST_HARD_VIOL_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_open && !txn_start && viol_valid && !viol_approx) |=> abort_req); // R2
    AST_ABORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |=> !abort_req); // R2
    AST_IDLE_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (!txn_open && !txn_start) |=> !abort_req); // R5

endmodule

// File: tb/avs_ctrl_tb.sv
// Self-checking bench: every event is applied to the DUT and to an
// arithmetic model built from the requirements; all outputs are compared.
module avs_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MAXS       = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr_en = 1'b0;
    logic       cfg_sel = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       txn_start = 1'b0;
    logic [3:0] txn_budget = '0;
    logic       txn_commit = 1'b0;
    logic       viol_valid = 1'b0;
    logic       viol_approx = 1'b0;
    logic       abort_req;
    logic [2:0] vstep;
    logic [3:0] ign_cnt;
    logic [7:0] commit_cnt;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 0;

    // Reference model state
    bit m_in = 0;
    int m_bud = 0, m_ign = 0, m_cnt = 0, m_step = 0;
    int m_high = 100, m_low = 10;
    bit m_abort = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    avs_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .txn_start(txn_start), .txn_budget(txn_budget),
        .txn_commit(txn_commit), .viol_valid(viol_valid), .viol_approx(viol_approx),
        .abort_req(abort_req), .vstep(vstep), .ign_cnt(ign_cnt), .commit_cnt(commit_cnt)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk(req, "abort_req", int'(abort_req), int'(m_abort));
        chk(req, "vstep", int'(vstep), m_step);
        chk(req, "commit_cnt", int'(commit_cnt), m_cnt);
        chk(req, "ign_cnt", int'(ign_cnt), m_ign);
    endtask

    // Apply one cycle of events (called at a negedge), update model, check.
    task automatic ev(input bit s, input int b, input bit c, input bit v, input bit a,
                      input string req);
        bit ab, cm;
        txn_start   = s;
        txn_budget  = 4'(b);
        txn_commit  = c;
        viol_valid  = v;
        viol_approx = a;
        @(posedge clk);
        ab = 0; cm = 0;
        if (s) begin
            m_in = 1; m_ign = 0; m_bud = b;
        end else if (m_in) begin
            if (v && (!a || m_ign + 1 > m_bud)) ab = 1;
            else if (v) m_ign++;
            if (ab) begin m_in = 0; m_ign = 0; end
            else if (c) begin m_in = 0; cm = 1; end
        end
        if (ab) begin
            if (m_cnt < m_low && m_step > 0) m_step--;
            m_cnt = 0;
        end else if (cm) begin
            if (m_cnt + 1 > m_high) begin
                m_cnt = 0;
                if (m_step < MAXS) m_step++;
            end else m_cnt++;
        end
        m_abort = ab;
        @(negedge clk);
        txn_start = 0; txn_commit = 0; viol_valid = 0; viol_approx = 0;
        chk_all(req);
    endtask

    task automatic idle(input string req);
        ev(0, 0, 0, 0, 0, req);
    endtask

    task automatic cfg(input bit sel, input int val);
        cfg_wr_en = 1; cfg_sel = sel; cfg_wdata = 8'(val);
        @(posedge clk);
        if (sel) m_low = val; else m_high = val;
        @(negedge clk);
        cfg_wr_en = 0;
    endtask

    task automatic commit_txn(input string req);
        ev(1, 0, 0, 0, 0, req);
        ev(0, 0, 1, 0, 0, req);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk_all("R1");

        // R1/R6: default lowering threshold of 100
        for (int i = 0; i < 101; i++) commit_txn("R6");
        chk("R1", "vstep after 101 commits", int'(vstep), 1);

        // R7: abort after few commits raises supply; at step 0 it holds (R8)
        for (int i = 0; i < 5; i++) commit_txn("R7");
        ev(1, 2, 0, 0, 0, "R7");
        ev(0, 0, 0, 1, 0, "R2");
        idle("R2");
        ev(1, 2, 0, 0, 0, "R8");
        ev(0, 0, 0, 1, 0, "R8");
        idle("R8");

        // R7: abort with enough commits keeps the step
        for (int i = 0; i < 10; i++) commit_txn("R7");
        ev(1, 0, 0, 0, 0, "R7");
        ev(0, 0, 0, 1, 0, "R7");
        idle("R7");

        // R9: small programmed thresholds
        cfg(0, 2);
        cfg(1, 1);
        for (int i = 0; i < 3; i++) commit_txn("R9");

        // R3/R4: sweep budget against approximatable violation count
        for (int b = 0; b < 4; b++) begin
            for (int n = 0; n < 6; n++) begin
                ev(1, b, 0, 0, 0, "R4");
                for (int k = 0; k < n; k++) ev(0, 0, 0, 1, 1, "R3");
                if (m_in) ev(0, 0, 1, 0, 0, "R6");
                idle("R3");
            end
        end

        // R8: saturation at the low-supply end
        for (int i = 0; i < 24; i++) commit_txn("R8");
        chk("R8", "vstep at top", int'(vstep), MAXS);

        // R5: events without an open transaction
        ev(0, 0, 0, 1, 0, "R5");
        ev(0, 0, 0, 1, 1, "R5");
        ev(0, 0, 1, 0, 0, "R5");

        // R4: restart while open clears the count; start cycle ignores events
        ev(1, 3, 0, 0, 0, "R4");
        ev(0, 0, 0, 1, 1, "R4");
        ev(1, 1, 0, 1, 0, "R4");
        ev(0, 0, 0, 1, 1, "R4");

        // R10: aborting violation and commit in the same cycle
        ev(0, 0, 1, 1, 0, "R10");
        idle("R10");
        ev(1, 0, 0, 0, 0, "R10");
        ev(0, 0, 1, 1, 1, "R10");
        idle("R10");

        finish_run();
    end
endmodule